// File: doc/BRIEF.md
# Time-Multiplexed Sixteen-Port UART

This block runs sixteen independent asynchronous serial ports from one shared bit-level engine. Replicating a full transmitter and receiver per port would cost sixteen copies of the same logic. Instead, the working state of every port lives in small distributed-RAM tables: the transmit and receive bit counters, the oversampling phases, the shift data and the baud accumulator. A round-robin slot counter selects one channel on every clock. The engine reads that channel's row, advances its transmit and receive machines by one step and writes the row back in the same cycle, so each port is serviced once every sixteen clocks.

Every frame has a start bit, eight data bits sent least significant bit first, and one stop bit. There is no parity. Each port has its own baud divisor, written through a configuration port, and the shared engine oversamples each bit sixteen times. Each direction has a single holding byte per port. The host fills a port's transmit holding byte with a write strobe and takes a received byte through a read strobe that returns the data in the same cycle. Each port has two flow-control lines. The transmitter waits for its clear-to-send input. The port lowers its ready-to-receive output while a received byte is waiting to be read.

Top module: `uart_tdm`

## Requirements
- R1: After reset all `tx_o` lines are high (idle), all `rts_o` lines are high, and `tx_full_o`, `rx_full_o`, `ferr_o` and `ovr_o` are all zero.
- R2: A transmitted frame is one low start bit, then the 8 data bits with bit 0 first, then one high stop bit. Each bit lasts exactly 256*(D+1) clock cycles, where D is the divisor written for that channel.
- R3: A host write to a channel whose transmit holding byte is empty shows `tx_full_o` high for that channel after the next clock edge. A write while `tx_full_o` is already high is ignored, and the byte already held is the one sent.
- R4: A transmitter starts a frame only while its `cts_i` is high. While `cts_i` stays low, `tx_o` stays high and `tx_full_o` stays set.
- R5: The receiver samples at 16 times the bit rate and confirms a start bit only if the line is still low half a bit time after the falling edge. A shorter low pulse produces no byte and no error.
- R6: A frame received with a high stop bit stores its byte and sets `rx_full_o`. With `rd_en` high and `rd_ch` selecting the channel, `rd_data` shows the byte in the same cycle, and `rx_full_o` clears after that clock edge.
- R7: A frame whose stop bit is sampled low sets `ferr_o` for that channel, discards the byte and leaves `rx_full_o` unchanged.
- R8: A byte that completes while `rx_full_o` is set, and is not being read in that cycle, sets `ovr_o` and is discarded. The held byte is kept.
- R9: If a read of a channel falls in the same cycle that the engine completes a new byte for it, `rd_data` returns the old byte, the new byte is stored, `rx_full_o` stays set and `ovr_o` stays clear.
- R10: `rts_o` of a channel is low exactly while its `rx_full_o` is set.
- R11: Channels run independently, each at its own divisor. The engine services one channel per clock, so at most one `tx_o` line changes on any clock edge.
- R12: A read of a channel clears that channel's `ferr_o` and `ovr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_en | input | 1 | Write strobe for a channel's baud divisor |
| cfg_ch | input | 4 | Channel addressed by the divisor write |
| cfg_div | input | 12 | Divisor D; bit time is 256*(D+1) clocks |
| wr_en | input | 1 | Host transmit write strobe |
| wr_ch | input | 4 | Channel addressed by the transmit write |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Host receive read strobe |
| rd_ch | input | 4 | Channel addressed by the read |
| rd_data | output | 8 | Received holding byte of `rd_ch` (combinational) |
| tx_full_o | output | 16 | Per-channel transmit holding byte occupied |
| rx_full_o | output | 16 | Per-channel receive holding byte occupied |
| ferr_o | output | 16 | Per-channel framing-error flag |
| ovr_o | output | 16 | Per-channel overrun flag |
| tx_o | output | 16 | Serial transmit lines |
| rx_i | input | 16 | Serial receive lines |
| rts_o | output | 16 | Ready-to-receive, high when the receive byte is free |
| cts_i | input | 16 | Clear-to-send, high lets the transmitter start |

## Verification
A host read and the engine's delivery of a freshly received byte can fall in the same clock cycle on the same channel. The bench provokes this on a channel set to divisor 0. It finds the channel's service slot from the edge at which that channel's transmit line falls. It then drives a frame whose falling edge is placed just after that slot, and raises `rd_en` in exactly the cycle of the stop-bit sample, 2448 clocks later. The collision is judged correct when `rd_data` shows the older byte in that cycle, `rx_full_o` stays set with `ovr_o` clear, and a following read returns the newer byte.

// File: rtl/uart_tdm_pkg.sv
package uart_tdm_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned BIT_W  = $clog2(DATA_W);
  localparam int unsigned OSR    = 16;
  localparam int unsigned PH_W   = $clog2(OSR);
  localparam int unsigned IDX_W  = 4;

  // index 0 = start bit, 1..DATA_W = data, DATA_W+1 = stop bit
  localparam logic [IDX_W-1:0] STOP_IDX = IDX_W'(DATA_W + 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(OSR - 1);
  localparam logic [PH_W-1:0]  PH_MID   = PH_W'(OSR / 2 - 1);

  typedef struct packed {
    logic              busy;
    logic [IDX_W-1:0]  idx;
    logic [PH_W-1:0]   phase;
    logic [DATA_W-1:0] data;
  } tx_st_t;

  typedef struct packed {
    logic              busy;
    logic [IDX_W-1:0]  idx;
    logic [PH_W-1:0]   phase;
    logic [DATA_W-1:0] shift;
  } rx_st_t;

  localparam tx_st_t TX_IDLE = '{busy: 1'b0, idx: '0, phase: '0, data: '0};
  localparam rx_st_t RX_IDLE = '{busy: 1'b0, idx: '0, phase: '0, shift: '0};
endpackage

// File: rtl/uart_tdm_seq.sv
module uart_tdm_seq #(
  parameter  int unsigned NUM_CH = 16,
  localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [CH_W-1:0] ch_o,
  output logic            sweep_o
);
  logic [CH_W-1:0] ch_q, ch_n;
  logic            sweep_q, sweep_n;
  logic            last;

  always_comb begin
    last    = (ch_q == CH_W'(NUM_CH - 1));
    ch_n    = last ? '0 : ch_q + CH_W'(1);
    sweep_n = sweep_q && !last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q    <= '0;
      sweep_q <= 1'b1;
    end else begin
      ch_q    <= ch_n;
      sweep_q <= sweep_n;
    end
  end

  assign ch_o    = ch_q;
  assign sweep_o = sweep_q;
endmodule

// File: rtl/uart_tdm_tx_step.sv
module uart_tdm_tx_step
  import uart_tdm_pkg::*;
(
  input  logic              tick,
  input  tx_st_t            st,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              cts,
  output tx_st_t            st_n,
  output logic              load,
  output logic              line
);
  always_comb begin
    st_n = st;
    load = 1'b0;
    if (tick) begin
      if (!st.busy) begin
        if (hold_full && cts) begin
          st_n.busy  = 1'b1;
          st_n.idx   = '0;
          st_n.phase = '0;
          st_n.data  = hold_data;
          load       = 1'b1;
        end
      end else begin
        st_n.phase = st.phase + PH_W'(1);
        if (st.phase == PH_LAST) begin
          if (st.idx == STOP_IDX) st_n.busy = 1'b0;
          else                    st_n.idx  = st.idx + IDX_W'(1);
        end
      end
    end
    if (!st_n.busy)                 line = 1'b1;
    else if (st_n.idx == '0)        line = 1'b0;
    else if (st_n.idx == STOP_IDX)  line = 1'b1;
    else                            line = st_n.data[BIT_W'(st_n.idx - IDX_W'(1))];
  end
endmodule

// File: rtl/uart_tdm_rx_step.sv
module uart_tdm_rx_step
  import uart_tdm_pkg::*;
(
  input  logic   tick,
  input  rx_st_t st,
  input  logic   line,
  output rx_st_t st_n,
  output logic   done_ok,
  output logic   done_bad
);
  always_comb begin
    st_n     = st;
    done_ok  = 1'b0;
    done_bad = 1'b0;
    if (tick) begin
      if (!st.busy) begin
        if (!line) begin
          st_n.busy  = 1'b1;
          st_n.idx   = '0;
          st_n.phase = '0;
        end
      end else if (st.idx == '0) begin
        if (st.phase == PH_MID) begin
          if (line) begin
            st_n.busy = 1'b0;
          end else begin
            st_n.idx   = IDX_W'(1);
            st_n.phase = '0;
          end
        end else begin
          st_n.phase = st.phase + PH_W'(1);
        end
      end else begin
        st_n.phase = st.phase + PH_W'(1);
        if (st.phase == PH_LAST) begin
          if (st.idx == STOP_IDX) begin
            st_n.busy = 1'b0;
            done_ok   = line;
            done_bad  = !line;
          end else begin
            st_n.shift = {line, st.shift[DATA_W-1:1]};
            st_n.idx   = st.idx + IDX_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/uart_tdm.sv
module uart_tdm
  import uart_tdm_pkg::*;
#(
  parameter  int unsigned NUM_CH = 16,
  parameter  int unsigned DIV_W  = 12,
  localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [CH_W-1:0]   rd_ch,
  output logic [DATA_W-1:0] rd_data,
  output logic [NUM_CH-1:0] tx_full_o,
  output logic [NUM_CH-1:0] rx_full_o,
  output logic [NUM_CH-1:0] ferr_o,
  output logic [NUM_CH-1:0] ovr_o,
  output logic [NUM_CH-1:0] tx_o,
  input  logic [NUM_CH-1:0] rx_i,
  output logic [NUM_CH-1:0] rts_o,
  input  logic [NUM_CH-1:0] cts_i
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  // two-stage synchronizers on the asynchronous line inputs
  logic [NUM_CH-1:0] rx_m, rx_s, cts_m, cts_s;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rx_m  <= '1;
      rx_s  <= '1;
      cts_m <= '0;
      cts_s <= '0;
    end else begin
      rx_m  <= rx_i;
      rx_s  <= rx_m;
      cts_m <= cts_i;
      cts_s <= cts_m;
    end
  end

  // slot sequencer
  logic [CH_W-1:0] ch;
  logic            sweep;

  uart_tdm_seq #(.NUM_CH(NUM_CH)) i_seq (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .ch_o    (ch),
    .sweep_o (sweep)
  );

  // per-channel state tables (distributed RAM, no reset)
  tx_st_t            tx_mem  [NUM_CH];
  rx_st_t            rx_mem  [NUM_CH];
  logic [DIV_W-1:0]  acc_mem [NUM_CH];
  logic [DIV_W-1:0]  div_mem [NUM_CH];
  logic [DATA_W-1:0] txh_mem [NUM_CH];
  logic [DATA_W-1:0] rxh_mem [NUM_CH];

  // per-channel flags and line registers
  logic [NUM_CH-1:0] tx_full_q, tx_full_n;
  logic [NUM_CH-1:0] rx_full_q, rx_full_n;
  logic [NUM_CH-1:0] ferr_q, ferr_n;
  logic [NUM_CH-1:0] ovr_q, ovr_n;
  logic [NUM_CH-1:0] tx_q, tx_n;

  // shared engine
  tx_st_t           tx_cur, tx_step_n, tx_wr;
  rx_st_t           rx_cur, rx_step_n, rx_wr;
  logic [DIV_W-1:0] acc_cur, acc_wr;
  logic             tick, tx_load, tx_line, rx_ok, rx_bad;
  logic             wr_ok, rd_same, rx_store;

  assign tx_cur  = tx_mem[ch];
  assign rx_cur  = rx_mem[ch];
  assign acc_cur = acc_mem[ch];
  assign tick    = !sweep && (acc_cur >= div_mem[ch]);

  uart_tdm_tx_step i_tx (
    .tick      (tick),
    .st        (tx_cur),
    .hold_full (tx_full_q[ch]),
    .hold_data (txh_mem[ch]),
    .cts       (cts_s[ch]),
    .st_n      (tx_step_n),
    .load      (tx_load),
    .line      (tx_line)
  );

  uart_tdm_rx_step i_rx (
    .tick     (tick),
    .st       (rx_cur),
    .line     (rx_s[ch]),
    .st_n     (rx_step_n),
    .done_ok  (rx_ok),
    .done_bad (rx_bad)
  );

  always_comb begin
    if (sweep) begin
      tx_wr  = TX_IDLE;
      rx_wr  = RX_IDLE;
      acc_wr = '0;
    end else begin
      tx_wr  = tx_step_n;
      rx_wr  = rx_step_n;
      acc_wr = tick ? '0 : acc_cur + DIV_W'(1);
    end
  end

  // flag next-state
  always_comb begin
    wr_ok    = wr_en && !tx_full_q[wr_ch];
    rd_same  = rd_en && (rd_ch == ch);
    rx_store = rx_ok && (!rx_full_q[ch] || rd_same);

    tx_full_n = tx_full_q;
    if (tx_load) tx_full_n[ch]    = 1'b0;
    if (wr_ok)   tx_full_n[wr_ch] = 1'b1;

    rx_full_n = rx_full_q;
    ferr_n    = ferr_q;
    ovr_n     = ovr_q;
    if (rd_en) begin
      rx_full_n[rd_ch] = 1'b0;
      ferr_n[rd_ch]    = 1'b0;
      ovr_n[rd_ch]     = 1'b0;
    end
    if (rx_store)           rx_full_n[ch] = 1'b1;
    if (rx_ok && !rx_store) ovr_n[ch]     = 1'b1;
    if (rx_bad)             ferr_n[ch]    = 1'b1;

    tx_n     = tx_q;
    tx_n[ch] = sweep ? 1'b1 : tx_line;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      tx_full_q <= '0;
      rx_full_q <= '0;
      ferr_q    <= '0;
      ovr_q     <= '0;
      tx_q      <= '1;
    end else begin
      tx_full_q <= tx_full_n;
      rx_full_q <= rx_full_n;
      ferr_q    <= ferr_n;
      ovr_q     <= ovr_n;
      tx_q      <= tx_n;
    end
  end

  // table writes
  always_ff @(posedge clk) begin
    tx_mem[ch]  <= tx_wr;
    rx_mem[ch]  <= rx_wr;
    acc_mem[ch] <= acc_wr;
    if (cfg_en)   div_mem[cfg_ch] <= cfg_div;
    if (wr_ok)    txh_mem[wr_ch]  <= wr_data;
    if (rx_store) rxh_mem[ch]     <= rx_step_n.shift;
  end

  assign rd_data   = rxh_mem[rd_ch];
  assign tx_full_o = tx_full_q;
  assign rx_full_o = rx_full_q;
  assign ferr_o    = ferr_q;
  assign ovr_o     = ovr_q;
  assign tx_o      = tx_q;
  assign rts_o     = ~rx_full_q;
endmodule

// File: rtl/uart_tdm_chk.sv
module uart_tdm_chk #(
  parameter  int unsigned NUM_CH = 16,
  localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [CH_W-1:0]   wr_ch,
  input logic              rd_en,
  input logic [CH_W-1:0]   rd_ch,
  input logic [NUM_CH-1:0] cts_i,
  input logic [NUM_CH-1:0] tx_o,
  input logic [NUM_CH-1:0] tx_full_o,
  input logic [NUM_CH-1:0] rx_full_o,
  input logic [NUM_CH-1:0] ferr_o,
  input logic [NUM_CH-1:0] ovr_o
);
  AST_TX_FULL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !tx_full_o[wr_ch] |=> tx_full_o[$past(wr_ch)]) else $error("AST_TX_FULL_SET"); // R3

  AST_ONE_LINE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tx_o ^ $past(tx_o)) <= 1) else $error("AST_ONE_LINE_EDGE"); // R11

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    AST_CTS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      tx_full_o[i] && !cts_i[i] && !$past(cts_i[i]) && !$past(cts_i[i], 2) |=> tx_full_o[i])
      else $error("AST_CTS_BLOCKS"); // R4

    AST_OVR_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_o[i]) |-> rx_full_o[i]) else $error("AST_OVR_KEEPS_FULL"); // R8

    AST_FERR_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ferr_o[i]) && !$past(rd_en && (rd_ch == CH_W'(i))) |-> $stable(rx_full_o[i]))
      else $error("AST_FERR_NO_STORE"); // R7
  end
endmodule

bind uart_tdm uart_tdm_chk #(.NUM_CH(NUM_CH)) i_chk (
  .clk       (clk),
  .rst_n     (rst_s_n),
  .wr_en     (wr_en),
  .wr_ch     (wr_ch),
  .rd_en     (rd_en),
  .rd_ch     (rd_ch),
  .cts_i     (cts_i),
  .tx_o      (tx_o),
  .tx_full_o (tx_full_o),
  .rx_full_o (rx_full_o),
  .ferr_o    (ferr_o),
  .ovr_o     (ovr_o)
);

// File: tb/test_uart_tdm.sv
module test_uart_tdm;
  localparam int NCH = 16;

  logic        clk, rst_n;
  logic        cfg_en, wr_en, rd_en;
  logic [3:0]  cfg_ch, wr_ch, rd_ch;
  logic [11:0] cfg_div;
  logic [7:0]  wr_data, rd_data;
  logic [NCH-1:0] tx_full_o, rx_full_o, ferr_o, ovr_o, tx_o, rx_i, rts_o, cts_i;
  logic [NCH-1:0] loop_m, man_rx;

  int n_chk, n_bad;
  bit done;

  assign rx_i = (loop_m & tx_o) | (~loop_m & man_rx);

  uart_tdm i_uart_tdm (
    .clk(clk), .rst_n(rst_n),
    .cfg_en(cfg_en), .cfg_ch(cfg_ch), .cfg_div(cfg_div),
    .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
    .rd_en(rd_en), .rd_ch(rd_ch), .rd_data(rd_data),
    .tx_full_o(tx_full_o), .rx_full_o(rx_full_o), .ferr_o(ferr_o), .ovr_o(ovr_o),
    .tx_o(tx_o), .rx_i(rx_i), .rts_o(rts_o), .cts_i(cts_i)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {channel[3:0], divisor[3:0], data[7:0]}
  localparam logic [15:0] VEC [8] = '{
    {4'd0,  4'd0, 8'h55}, {4'd1,  4'd1, 8'h80}, {4'd4,  4'd0, 8'h00},
    {4'd6,  4'd2, 8'hC3}, {4'd8,  4'd0, 8'hFF}, {4'd10, 4'd1, 8'h24},
    {4'd13, 4'd0, 8'h01}, {4'd15, 4'd1, 8'h9A}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int low_bits(input logic [7:0] d);
    int n = 1;
    for (int b = 0; b < 8; b++) begin
      if (d[b]) return n;
      n++;
    end
    return n;
  endfunction

  task automatic set_div(input int c, input int d);
    cfg_ch = 4'(c); cfg_div = 12'(d); cfg_en = 1'b1;
    @(negedge clk);
    cfg_en = 1'b0;
  endtask

  task automatic host_wr(input int c, input logic [7:0] d);
    wr_ch = 4'(c); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic host_rd(input int c, output logic [7:0] d);
    rd_ch = 4'(c); rd_en = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_rx(input int c, input int lim, output bit got);
    got = 1'b0;
    for (int k = 0; k < lim; k++) begin
      if (rx_full_o[c]) begin got = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic wait_tx_low(input int c, input int lim, output bit got);
    got = 1'b0;
    for (int k = 0; k < lim; k++) begin
      if (!tx_o[c]) begin got = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic drive_frame(input int c, input logic [7:0] d, input logic stop, input int bt);
    man_rx[c] = 1'b0;
    repeat (bt) @(negedge clk);
    for (int b = 0; b < 8; b++) begin
      man_rx[c] = d[b];
      repeat (bt) @(negedge clk);
    end
    man_rx[c] = stop;
    repeat (bt) @(negedge clk);
    man_rx[c] = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, got_b;
    bit ok;
    int run;
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0;
    cfg_en = 0; wr_en = 0; rd_en = 0;
    cfg_ch = 0; wr_ch = 0; rd_ch = 0; cfg_div = 0; wr_data = 0;
    loop_m = '0; man_rx = '1; cts_i = '1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);

    // R1 reset state
    check(tx_o == '1, "R1 tx idle", tx_o, 16'hFFFF);
    check(rts_o == '1, "R1 rts", rts_o, 16'hFFFF);
    check((tx_full_o | rx_full_o | ferr_o | ovr_o) == '0, "R1 flags", tx_full_o | rx_full_o | ferr_o | ovr_o, 0);

    // vector table, loopback per channel
    foreach (VEC[v]) begin
      automatic int c   = int'(VEC[v][15:12]);
      automatic int dv  = int'(VEC[v][11:8]);
      automatic logic [7:0] dat = VEC[v][7:0];
      set_div(c, dv);
      loop_m[c] = 1'b1;
      host_wr(c, dat);
      check(tx_full_o[c], "R3 tx_full set", tx_full_o[c], 1);
      wait_tx_low(c, 20000, ok);
      check(ok, "R2 start bit seen", ok, 1);
      run = 0;
      while (!tx_o[c] && run < 40000) begin @(negedge clk); run++; end
      check(run == 256 * (dv + 1) * low_bits(dat), "R2 bit timing", run, 256 * (dv + 1) * low_bits(dat));
      wait_rx(c, 40000, ok);
      check(ok, "R6 rx_full", ok, 1);
      check(!rts_o[c], "R10 rts low when full", rts_o[c], 0);
      host_rd(c, got_b);
      check(got_b == dat, "R6 loopback data", got_b, dat);
      check(!rx_full_o[c] && rts_o[c], "R10 rts back after read", {rx_full_o[c], rts_o[c]}, 1);
      check(!ferr_o[c] && !ovr_o[c], "R6 no error", {ferr_o[c], ovr_o[c]}, 0);
      repeat (300 * (dv + 1)) @(negedge clk);
      loop_m[c] = 1'b0;
    end

    // R4 CTS hold and R3 ignored second write
    set_div(2, 0);
    cts_i[2] = 1'b0;
    loop_m[2] = 1'b1;
    host_wr(2, 8'hA5);
    host_wr(2, 8'h3C);
    run = 0;
    for (int k = 0; k < 3000; k++) begin
      if (!tx_o[2]) run++;
      @(negedge clk);
    end
    check(run == 0, "R4 line idle without cts", run, 0);
    check(tx_full_o[2], "R4 tx_full kept", tx_full_o[2], 1);
    cts_i[2] = 1'b1;
    wait_rx(2, 6000, ok);
    host_rd(2, got_b);
    check(ok && got_b == 8'hA5, "R3 second write ignored", got_b, 8'hA5);
    repeat (400) @(negedge clk);
    loop_m[2] = 1'b0;

    // R8 overrun, R12 clear on read
    set_div(7, 0);
    loop_m[7] = 1'b1;
    host_wr(7, 8'h11);
    wait_rx(7, 6000, ok);
    host_wr(7, 8'h22);
    repeat (3500) @(negedge clk);
    check(ovr_o[7], "R8 overrun set", ovr_o[7], 1);
    check(rx_full_o[7], "R8 still full", rx_full_o[7], 1);
    host_rd(7, got_b);
    check(got_b == 8'h11, "R8 old byte kept", got_b, 8'h11);
    check(!ovr_o[7], "R12 overrun cleared", ovr_o[7], 0);
    loop_m[7] = 1'b0;

    // R7 framing error, R12 clear
    set_div(9, 0);
    drive_frame(9, 8'h81, 1'b0, 256);
    repeat (600) @(negedge clk);
    check(ferr_o[9], "R7 ferr set", ferr_o[9], 1);
    check(!rx_full_o[9], "R7 byte dropped", rx_full_o[9], 0);
    host_rd(9, got_b);
    check(!ferr_o[9], "R12 ferr cleared", ferr_o[9], 0);

    // R5 short low pulse rejected
    man_rx[9] = 1'b0;
    repeat (100) @(negedge clk);
    man_rx[9] = 1'b1;
    repeat (3000) @(negedge clk);
    check(!rx_full_o[9] && !ferr_o[9], "R5 glitch ignored", {rx_full_o[9], ferr_o[9]}, 0);

    // R11 two channels at different rates together
    set_div(3, 1);
    set_div(12, 2);
    loop_m[3] = 1'b1; loop_m[12] = 1'b1;
    host_wr(3, 8'h6B);
    host_wr(12, 8'hD2);
    wait_rx(12, 20000, ok);
    check(rx_full_o[3] && rx_full_o[12], "R11 both received", {rx_full_o[3], rx_full_o[12]}, 3);
    host_rd(3, got_b);
    check(got_b == 8'h6B, "R11 ch3 data", got_b, 8'h6B);
    host_rd(12, got_b);
    check(got_b == 8'hD2, "R11 ch12 data", got_b, 8'hD2);
    repeat (1000) @(negedge clk);
    loop_m[3] = 1'b0; loop_m[12] = 1'b0;

    // R9 read in the cycle the next byte completes
    set_div(5, 0);
    drive_frame(5, 8'h5A, 1'b1, 256);
    repeat (300) @(negedge clk);
    check(rx_full_o[5], "R9 first byte held", rx_full_o[5], 1);
    host_wr(5, 8'hFF);
    wait_tx_low(5, 200, ok);
    man_rx[5] = 1'b0;
    fork
      begin
        repeat (256) @(negedge clk);
        for (int b = 0; b < 8; b++) begin
          man_rx[5] = d_bit(8'hC7, b);
          repeat (256) @(negedge clk);
        end
        man_rx[5] = 1'b1;
        repeat (256) @(negedge clk);
      end
      begin
        repeat (2447) @(negedge clk);
        rd_ch = 4'd5; rd_en = 1'b1;
        #1 got_b = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
      end
    join
    check(got_b == 8'h5A, "R9 old byte on collision", got_b, 8'h5A);
    check(rx_full_o[5] && !ovr_o[5], "R9 no overrun", {rx_full_o[5], ovr_o[5]}, 2);
    host_rd(5, got_b);
    check(got_b == 8'hC7, "R9 new byte stored", got_b, 8'hC7);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  function automatic logic d_bit(input logic [7:0] d, input int b);
    return d[b];
  endfunction
endmodule